// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one read or write burst for a double-data-rate memory whose core fetches two words per access. A start pulse supplies the first column of the burst. The block then presents two column addresses on every clock, the even beat and the odd beat of each core access, until the burst is complete. The burst covers an aligned block whose size is the programmed burst length. Within that block the addresses follow either a wrapping linear count or an XOR pattern.

Burst length and order come from a mode-register write, which the block decodes itself. A reserved code is flagged and leaves the previous settings in place. A burst copies the current settings when it starts, so a mode write during a burst does not affect that burst. An early-stop input shortens a running burst. A new start may be issued in the final cycle of a burst, so that bursts run back to back without a gap.

The controller is a two-state machine. `ST_IDLE` leaves on an accepted start (transition *launch*) and goes to `ST_BURST`. In `ST_BURST` the machine steps to the next pair on each clock (transition *advance*). In the final pair it does one of two things: with a new start it reloads and stays in `ST_BURST` (transition *restart*); with no start it returns to `ST_IDLE` (transition *finish*). A sampled stop request makes the following pair the final one.

Top module: `burst_addr_seq`

## Requirements
- R1: A mode write with bits [2:0] equal to 001, 010 or 011 sets `cfg_burst_len` to 2, 4 or 8 on the cycle after the write.
- R2: Mode bit 3 selects the order (0 linear, 1 XOR) and appears on `cfg_interleave`. The latency field in bits [6:4] must be 011, which reports `cfg_latency` = 3.
- R3: A mode write with any other length code, or with any other latency code, sets `mode_err` and leaves every setting unchanged. A legal write clears `mode_err`.
- R4: After reset the settings are length 2, linear order and latency 3, with `mode_err`, `col_valid` and `done` all low.
- R5: A start accepted at a clock edge gives `col_valid` with the first pair from the next cycle on. A full burst of length BL holds `col_valid` for BL/2 cycles. `done` is high only in the final cycle, after which `col_valid` falls unless a new burst starts.
- R6: In linear order, beat k of a burst of length BL starting at low bits s uses the low bits (s & ~(BL-1)) | ((s + k) mod BL). For example, length 8 from 5 gives 5,6,7,0,1,2,3,4.
- R7: In XOR order, beat k uses the low bits s XOR k. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R8: Column bits from 3 upward always equal those of the start column. `col_even` carries beat 2p and `col_odd` carries beat 2p+1 of pair p.
- R9: If `stop` is high at an edge while a burst is running and not in its final cycle, the next cycle carries the following pair with `done` high, and the burst then ends.
- R10: While a burst runs and is not in its final cycle, `start` is ignored. A mode write during a burst does not change the burst's length or order.
- R11: A start given in the final cycle of a burst launches the new burst in the very next cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_data | input | MODE_W | Mode-register operand |
| start | input | 1 | Begin a burst |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Early-stop request |
| col_even | output | COL_W | Column of the even beat of the current pair |
| col_odd | output | COL_W | Column of the odd beat of the current pair |
| col_valid | output | 1 | A pair is being presented |
| done | output | 1 | Final pair of the burst |
| cfg_burst_len | output | 4 | Programmed burst length (2, 4 or 8) |
| cfg_interleave | output | 1 | Programmed order, 1 = XOR |
| cfg_latency | output | 3 | Programmed read latency |
| mode_err | output | 1 | Last mode write carried a reserved code |

## Verification
The embedded assertions check several properties on every clock:
- the settings stay unchanged after a rejected mode write;
- the pair index stays within the burst length;
- the burst ends after `done`;
- a stop request makes the next cycle the final one;
- a start in mid-burst leaves the latched base alone;
- the upper column bits are equal across both lanes, and the two lanes differ only in bit 0 under XOR order.

Only the bench's scenarios show that each address matches the linear and XOR rules. The bench sweeps every length, order and starting offset for this. Its scenarios also cover the exact cycle on which bursts begin and end, the back-to-back restart, and that a mode write in mid-burst leaves the running burst unchanged.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Width of the in-block column offset (bursts up to 8 beats).
    localparam int BLK_W = 3;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

    // len_log: 1 -> 2 beats, 2 -> 4 beats, 3 -> 8 beats
    typedef struct packed {
        logic [1:0] len_log;
        order_e     order;
    } burst_cfg_t;

endpackage

// File: rtl/bseq_mode_dec.sv
module bseq_mode_dec
    import bseq_pkg::*;
#(
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] data,
    output burst_cfg_t        cfg,
    output logic [2:0]        latency,
    output logic              err
);

    localparam logic [2:0] LAT_CODE_3 = 3'b011;

    logic [1:0] dec_len_log;
    logic       len_ok;
    logic       lat_ok;

    always_comb begin
        len_ok      = 1'b1;
        dec_len_log = 2'd1;
        unique case (data[2:0])
            3'b001:  dec_len_log = 2'd1;
            3'b010:  dec_len_log = 2'd2;
            3'b011:  dec_len_log = 2'd3;
            default: len_ok = 1'b0;
        endcase
        lat_ok = (data[6:4] == LAT_CODE_3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.len_log <= 2'd1;
            cfg.order   <= ORD_LINEAR;
            latency     <= 3'd3;
            err         <= 1'b0;
        end else if (wr) begin
            if (len_ok && lat_ok) begin
                cfg.len_log <= dec_len_log;
                cfg.order   <= order_e'(data[3]);
                latency     <= 3'd3;
                err         <= 1'b0;
            end else begin
                err         <= 1'b1;
            end
        end
    end

    AST_RSVD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(len_ok && lat_ok)) |=> (err && $stable(cfg) && $stable(latency))); // R3

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.len_log != 2'd0)); // R1

endmodule

// File: rtl/bseq_order_gen.sv
module bseq_order_gen
    import bseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  burst_cfg_t       cfg,
    input  logic [1:0]       pair,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd
);

    localparam int NLANE = 2;

    logic [BLK_W-1:0] mask;

    always_comb begin
        unique case (cfg.len_log)
            2'd2:    mask = 3'b011;
            2'd3:    mask = 3'b111;
            default: mask = 3'b001;
        endcase
    end

    logic [COL_W-1:0] lane_col [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam logic LANE_BIT = 1'(g);
        logic [BLK_W-1:0] beat;
        logic [BLK_W-1:0] start_low;
        logic [BLK_W-1:0] sum;
        logic [BLK_W-1:0] low;

        always_comb begin
            beat      = {pair, LANE_BIT};
            start_low = base[BLK_W-1:0];
            sum       = start_low + beat;
            if (cfg.order == ORD_XOR) begin
                low = start_low ^ beat;
            end else begin
                low = (start_low & ~mask) | (sum & mask);
            end
            lane_col[g] = {base[COL_W-1:BLK_W], low};
        end
    end

    assign col_even = lane_col[0];
    assign col_odd  = lane_col[1];

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    input  burst_cfg_t       cfg_in,
    output logic [COL_W-1:0] base,
    output burst_cfg_t       run_cfg,
    output logic [1:0]       pair,
    output logic             valid,
    output logic             done
);

    seq_state_e state, state_nx;
    logic       stop_pend;
    logic [1:0] last_pair;
    logic       final_pair;
    logic       accept;

    always_comb begin
        unique case (run_cfg.len_log)
            2'd2:    last_pair = 2'd1;
            2'd3:    last_pair = 2'd3;
            default: last_pair = 2'd0;
        endcase
        final_pair = (state == ST_BURST) && ((pair == last_pair) || stop_pend);
        accept     = start && ((state == ST_IDLE) || final_pair);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_BURST;            // launch
            ST_BURST: if (final_pair && !start) state_nx = ST_IDLE; // finish
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // burst datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            run_cfg   <= '{len_log: 2'd1, order: ORD_LINEAR};
            pair      <= 2'd0;
            stop_pend <= 1'b0;
        end else if (accept) begin               // launch or restart
            base      <= start_col;
            run_cfg   <= cfg_in;
            pair      <= 2'd0;
            stop_pend <= 1'b0;
        end else if (state == ST_BURST && !final_pair) begin // advance
            pair      <= pair + 2'd1;
            stop_pend <= stop;
        end
    end

    // outputs
    always_comb begin
        valid = (state == ST_BURST);
        done  = final_pair;
    end

    AST_PAIR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (pair <= last_pair)); // R5

    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !valid); // R5

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !done && stop) |=> done); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !done && start) |=> (valid && $stable(base) && $stable(run_cfg))); // R10

    AST_RESTART_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (valid && pair == 2'd0)); // R11

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    output logic [COL_W-1:0]  col_even,
    output logic [COL_W-1:0]  col_odd,
    output logic              col_valid,
    output logic              done,
    output logic [3:0]        cfg_burst_len,
    output logic              cfg_interleave,
    output logic [2:0]        cfg_latency,
    output logic              mode_err
);

    burst_cfg_t       prog_cfg;
    burst_cfg_t       run_cfg;
    logic [COL_W-1:0] base;
    logic [1:0]       pair;

    bseq_mode_dec #(.MODE_W(MODE_W)) i_mode_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .data    (mode_data),
        .cfg     (prog_cfg),
        .latency (cfg_latency),
        .err     (mode_err)
    );

    bseq_ctrl #(.COL_W(COL_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .stop      (stop),
        .cfg_in    (prog_cfg),
        .base      (base),
        .run_cfg   (run_cfg),
        .pair      (pair),
        .valid     (col_valid),
        .done      (done)
    );

    bseq_order_gen #(.COL_W(COL_W)) i_order_gen (
        .base     (base),
        .cfg      (run_cfg),
        .pair     (pair),
        .col_even (col_even),
        .col_odd  (col_odd)
    );

    assign cfg_burst_len  = 4'(1) << prog_cfg.len_log;
    assign cfg_interleave = (prog_cfg.order == ORD_XOR);

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (col_even[COL_W-1:BLK_W] == col_odd[COL_W-1:BLK_W])); // R8

    AST_XOR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && run_cfg.order == ORD_XOR) |-> ((col_even ^ col_odd) == COL_W'(1))); // R7

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 9;
    localparam int MODE_W     = 13;
    localparam int WD_LIMIT   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_wr = 1'b0;
    logic [MODE_W-1:0] mode_data = '0;
    logic              start = 1'b0;
    logic [COL_W-1:0]  start_col = '0;
    logic              stop = 1'b0;
    logic [COL_W-1:0]  col_even, col_odd;
    logic              col_valid, done;
    logic [3:0]        cfg_burst_len;
    logic              cfg_interleave;
    logic [2:0]        cfg_latency;
    logic              mode_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    burst_addr_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) i_burst_addr_seq (
        .clk, .rst_n, .mode_wr, .mode_data, .start, .start_col, .stop,
        .col_even, .col_odd, .col_valid, .done,
        .cfg_burst_len, .cfg_interleave, .cfg_latency, .mode_err
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog R5 actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference: column of beat k for burst length bl
    function automatic int ref_col(input int s, input int bl, input int xo, input int k);
        int lo = s % 8;
        int hi = s - lo;
        int nl;
        if (xo != 0) nl = lo ^ k;
        else         nl = (lo - (lo % bl)) + ((lo + k) % bl);
        return hi + nl;
    endfunction

    function automatic logic [2:0] len_code(input int bl);
        return (bl == 2) ? 3'b001 : (bl == 4) ? 3'b010 : 3'b011;
    endfunction

    task automatic wr_mode(input logic [2:0] lc, input logic ty, input logic [2:0] lat);
        @(negedge clk);
        mode_wr   = 1'b1;
        mode_data = {{(MODE_W-7){1'b0}}, lat, ty, lc};
        @(negedge clk);
        mode_wr   = 1'b0;
    endtask

    task automatic set_mode(input int bl, input int xo);
        wr_mode(len_code(bl), 1'(xo), 3'b011);
    endtask

    // run and check a complete burst; ends at the negedge after the burst
    task automatic full_burst(input int s, input int bl, input int xo, input string req);
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(s);
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < bl/2; p++) begin
            chk({req, " valid"}, int'(col_valid), 1);
            chk({req, " even"}, int'(col_even), ref_col(s, bl, xo, 2*p));
            chk({req, " odd"},  int'(col_odd),  ref_col(s, bl, xo, 2*p+1));
            chk("R5 done timing", int'(done), (p == bl/2-1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R5 valid falls", int'(col_valid), 0);
    endtask

    initial begin
        // R4 reset state
        repeat (2) @(negedge clk);
        chk("R4 len", int'(cfg_burst_len), 2);
        chk("R4 order", int'(cfg_interleave), 0);
        chk("R4 latency", int'(cfg_latency), 3);
        chk("R4 err", int'(mode_err), 0);
        chk("R4 valid", int'(col_valid), 0);
        chk("R4 done", int'(done), 0);
        rst_n = 1'b1;

        // R1 / R2 decode
        for (int b = 1; b <= 3; b++) begin
            for (int t = 0; t < 2; t++) begin
                wr_mode(3'(b), 1'(t), 3'b011);
                chk("R1 length", int'(cfg_burst_len), 1 << b);
                chk("R2 order", int'(cfg_interleave), t);
                chk("R2 latency", int'(cfg_latency), 3);
                chk("R3 err clear", int'(mode_err), 0);
            end
        end

        // R3 reserved codes keep settings (now length 8, XOR)
        wr_mode(3'b100, 1'b0, 3'b011);
        chk("R3 err bl", int'(mode_err), 1);
        chk("R3 keep len", int'(cfg_burst_len), 8);
        chk("R3 keep order", int'(cfg_interleave), 1);
        wr_mode(3'b000, 1'b0, 3'b011);
        chk("R3 err bl0", int'(mode_err), 1);
        wr_mode(3'b001, 1'b0, 3'b010);
        chk("R3 err lat", int'(mode_err), 1);
        chk("R3 keep len lat", int'(cfg_burst_len), 8);
        chk("R3 keep order lat", int'(cfg_interleave), 1);
        wr_mode(3'b010, 1'b0, 3'b011);
        chk("R3 clear", int'(mode_err), 0);
        chk("R3 new len", int'(cfg_burst_len), 4);

        // R6 / R7 / R8 exhaustive sweep of length, order, start offset
        for (int b = 2; b <= 8; b *= 2) begin
            for (int t = 0; t < 2; t++) begin
                set_mode(b, t);
                for (int lo = 0; lo < 8; lo++) begin
                    int s = ((lo * 37 + b * 11 + t * 5) % 64) * 8 + lo;
                    full_burst(s, b, t, t ? "R7 R8" : "R6 R8");
                end
            end
        end

        // R9 stop after each pair of a length-8 linear burst
        set_mode(8, 0);
        for (int sp = 0; sp < 3; sp++) begin
            @(negedge clk);
            start = 1'b1; start_col = COL_W'(13);
            @(negedge clk);
            start = 1'b0;
            for (int p = 0; p < sp; p++) @(negedge clk);
            chk("R9 before stop", int'(done), 0);
            stop = 1'b1;
            @(negedge clk);
            stop = 1'b0;
            chk("R9 done", int'(done), 1);
            chk("R9 next pair", int'(col_even), ref_col(13, 8, 0, 2*(sp+1)));
            @(negedge clk);
            chk("R9 ended", int'(col_valid), 0);
        end

        // R10 start ignored mid-burst, mode write mid-burst
        set_mode(4, 1);
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(6);
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(40);
        mode_wr = 1'b1; mode_data = {{(MODE_W-7){1'b0}}, 3'b011, 1'b0, 3'b001};
        @(negedge clk);
        start = 1'b0; mode_wr = 1'b0;
        chk("R10 keeps base", int'(col_even), ref_col(6, 4, 1, 2));
        chk("R10 keeps order", int'(col_odd), ref_col(6, 4, 1, 3));
        chk("R10 keeps length", int'(done), 1);
        @(negedge clk);
        chk("R10 ended", int'(col_valid), 0);
        chk("R10 mode applied", int'(cfg_burst_len), 2);

        // R11 back-to-back length-2 bursts
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(3);
        @(negedge clk);
        start_col = COL_W'(100);
        chk("R11 first done", int'(done), 1);
        chk("R11 first col", int'(col_even), ref_col(3, 2, 0, 0));
        @(negedge clk);
        start = 1'b0;
        chk("R11 gapless valid", int'(col_valid), 1);
        chk("R11 second col", int'(col_even), ref_col(100, 2, 0, 0));
        chk("R11 second odd", int'(col_odd), ref_col(100, 2, 0, 1));
        @(negedge clk);
        chk("R11 ended", int'(col_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule